// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block decides which power state a small processor core is in and drives the clock gates that go with it. A power-save command selects a light Idle state or a Sleep state. In Idle the CPU clock stops and the peripheral clock keeps running. In Sleep both clocks stop. The sequencer also pulses the watchdog clear on Idle entry. It lets the command complete even when an interrupt arrives in the same cycle, and it reports when the core resumes and whether an interrupt caused the resume.

A third, deeper state uses a guarded two-step entry. Software first sets an arm bit, and a sleep-type command must follow on the very next cycle. If the command is late, the arm bit drops by itself. A deep-sleep request that comes too soon after the release-clear event is dropped. Only the dedicated deep-sleep wake sources can leave the deep state. A sticky wake-cause register records which of them fired, and the register is wiped each time the state is armed.

Top module: `lpm_seq`

## Requirements
- R1: `mode_o` is 1 (Idle) in the cycle after a command with `pwrsav_op_i`=1 is sampled in Run. In Idle, `cpu_clk_en_o`=0 and `sys_clk_en_o`=1. `wdt_clr_o` is high for the first Idle cycle only.
- R2: Idle and Sleep return to Run (`mode_o`=0) at the edge that samples any of the following: an interrupt line with both pend and enable bits set, `wdt_to_i`, or `mclr_i`. A pending line whose enable bit is clear has no effect. `resume_o` is high for the first Run cycle after the exit. `resume_isr_o` is also high in that cycle when an enabled interrupt caused the exit and `mclr_i` was not asserted.
- R3: An enabled interrupt sampled at the same edge as an Idle command does not block the entry. Idle lasts exactly one cycle, then Run follows.
- R4: `arm_set_i` sampled in Run without a command sets `arm_o` for one cycle. A command with `pwrsav_op_i`=0 sampled in that cycle enters deep sleep (`mode_o`=3). With no such command, `arm_o` clears at the next edge. A command with `pwrsav_op_i`=0 sampled while `arm_o`=0 enters Sleep (`mode_o`=2).
- R5: While in deep sleep, `arm_o`=1 and `ds_en_o`=1. Both drop at the exit edge.
- R6: Deep sleep exits only on `mclr_i`, `rtc_alarm_i`, `ext_int0_i` or `dswdt_to_i`. Interrupts and `wdt_to_i` are ignored there. Each deep-sleep source sets its own sticky `wake_cause_o` bit: bit 0 power-on, bit 1 master reset, bit 2 clock alarm, bit 3 external interrupt 0, bit 4 deep watchdog.
- R7: When `arm_o` is set, `wake_cause_o` reads all zeros in the same cycle.
- R8: With GAP_CYC=3, an armed sleep command is honoured only if it is sampled at least 4 edges after the edge that sampled `rel_clr_i`. An earlier command is dropped: the block stays in Run and `arm_o` clears.
- R9: Reset (`rst_n`=0 at an edge) sets `mode_o` to Run and clears `arm_o`. Afterwards `wake_cause_o` is 5'b00001. Modes encode as Run=0, Idle=1, Sleep=2, Deep=3.
- R10: In Sleep, `cpu_clk_en_o` and `sys_clk_en_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pwrsav_i | input | 1 | Power-save command strobe |
| pwrsav_op_i | input | 1 | Command operand: 1 Idle, 0 Sleep |
| arm_set_i | input | 1 | Software write that sets the deep-sleep arm bit |
| rel_clr_i | input | 1 | Release bit cleared (starts re-entry delay) |
| mclr_i | input | 1 | External master reset event |
| wdt_to_i | input | 1 | Main watchdog timeout |
| irq_pend_i | input | N_IRQ | Interrupt pending lines |
| irq_en_i | input | N_IRQ | Interrupt enable lines |
| rtc_alarm_i | input | 1 | Real-time clock alarm |
| ext_int0_i | input | 1 | External interrupt 0 |
| dswdt_to_i | input | 1 | Deep-sleep watchdog timeout |
| mode_o | output | 2 | Current mode |
| arm_o | output | 1 | Deep-sleep arm bit |
| wake_cause_o | output | 5 | Sticky deep-sleep wake causes |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| sys_clk_en_o | output | 1 | Peripheral clock gate enable |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| ds_en_o | output | 1 | Deep-sleep domain enable |
| resume_o | output | 1 | First Run cycle after a low-power exit |
| resume_isr_o | output | 1 | Resume was caused by an interrupt |

## Verification
The Idle exit is swept over every interrupt line, once with its enable set and once with it clear. This separates enabled wakes, which must resume into the handler, from masked lines, which must leave the core asleep until the watchdog wakes it. Each deep-sleep source is fired alone, and then all of them together. The solo runs prove that every source has its own cause bit. The combined run proves the bits accumulate, and the prior arm clear shows that no older cause survives. A sweep of the delay between the release-clear event and the armed command places the accept/drop boundary exactly. Late-arm, coincident-interrupt and mid-deep-reset cases cover the remaining edges.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode sequencer.
// Assumes: mode codes are visible to software and must stay fixed.
package lpm_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_SLEEP = 2'd2,
        MODE_DEEP  = 2'd3
    } pmode_e;

    localparam int WSRC_N   = 5;
    localparam int WB_POR   = 0;
    localparam int WB_MCLR  = 1;
    localparam int WB_RTC   = 2;
    localparam int WB_INT0  = 3;
    localparam int WB_DSWDT = 4;
endpackage

// File: rtl/lpm_irq_screen.sv
// Interrupt screen: reports whether any pending line is also enabled.
// Assumes: pend and enable are level signals synchronous to clk.
module lpm_irq_screen #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] pend_i,
    input  logic [N_IRQ-1:0] en_i,
    output logic             hit_o
);
    logic [N_IRQ-1:0] hit_vec;

    // qualify each line by its own enable
    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        assign hit_vec[g] = pend_i[g] & en_i[g];
    end

    // any qualified line wakes the core
    assign hit_o = |hit_vec;
endmodule

// File: rtl/lpm_arm_guard.sv
// Deep-sleep arm guard: holds the arm bit for a one-cycle window and
// counts cycles since the release bit was cleared.
// Assumes: stay_deep_i means the next mode is deep sleep.
module lpm_arm_guard #(
    parameter int GAP_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_set_i,
    input  logic rel_clr_i,
    input  logic mclr_i,
    input  logic run_i,
    input  logic cmd_i,
    input  logic stay_deep_i,
    input  logic deep_exit_i,
    output logic arm_o,
    output logic arm_load_o,
    output logic gap_ok_o
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(GAP_CYC);

    logic          arm_q;
    logic [GW-1:0] gap_q;

    // accepted software arm: only in Run and not during a command
    assign arm_load_o = arm_set_i && run_i && !cmd_i && !mclr_i;

    // arm bit: set by software, kept through deep sleep, otherwise one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                  arm_q <= 1'b0;
        else if (mclr_i || deep_exit_i) arm_q <= 1'b0;
        else if (arm_load_o)         arm_q <= 1'b1;
        else if (stay_deep_i)        arm_q <= arm_q;
        else                         arm_q <= 1'b0;
    end

    // saturating count of cycles since the release clear
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_q <= GAP_MAX;
        else if (rel_clr_i)        gap_q <= '0;
        else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    assign arm_o    = arm_q;
    assign gap_ok_o = (gap_q == GAP_MAX);
endmodule

// File: rtl/lpm_wake_log.sv
// Wake-cause log: sticky bits for each deep-sleep wake source.
// Assumes: power-on is signalled by the block reset itself.
module lpm_wake_log
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              capture_i,
    input  logic [WSRC_N-1:0] src_i,
    output logic [WSRC_N-1:0] cause_o
);
    localparam logic [WSRC_N-1:0] POR_ONLY = WSRC_N'(1) << WB_POR;

    logic [WSRC_N-1:0] cause_q;

    // power-on marks its bit, arming wipes, deep sleep accumulates
    always_ff @(posedge clk) begin
        if (!rst_n)         cause_q <= POR_ONLY;
        else if (clear_i)   cause_q <= '0;
        else if (capture_i) cause_q <= cause_q | src_i;
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
// Mode state machine: Run, Idle, Sleep and Deep with their exits, plus
// the registered entry and resume pulses.
// Assumes: arm and gap qualification come from the arm guard.
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pwrsav_i,
    input  logic   pwrsav_op_i,
    input  logic   arm_i,
    input  logic   gap_ok_i,
    input  logic   mclr_i,
    input  logic   wdt_to_i,
    input  logic   irq_hit_i,
    input  logic   ds_wake_i,
    output pmode_e mode_q_o,
    output pmode_e mode_d_o,
    output logic   wdt_clr_o,
    output logic   resume_o,
    output logic   resume_isr_o
);
    pmode_e mode_q, mode_d;
    logic   wdt_clr_q, resume_q, resume_isr_q;
    logic   light_wake;

    assign light_wake = mclr_i || wdt_to_i || irq_hit_i;

    // next-mode decision
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (pwrsav_i && !mclr_i) begin
                    if (pwrsav_op_i)   mode_d = MODE_IDLE;
                    else if (!arm_i)   mode_d = MODE_SLEEP;
                    else if (gap_ok_i) mode_d = MODE_DEEP;
                end
            end
            MODE_IDLE, MODE_SLEEP: begin
                if (light_wake) mode_d = MODE_RUN;
            end
            MODE_DEEP: begin
                if (mclr_i || ds_wake_i) mode_d = MODE_RUN;
            end
        endcase
    end

    // mode register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    // one-cycle pulses on Idle entry and on resume
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_clr_q    <= 1'b0;
            resume_q     <= 1'b0;
            resume_isr_q <= 1'b0;
        end else begin
            wdt_clr_q    <= (mode_q == MODE_RUN) && (mode_d == MODE_IDLE);
            resume_q     <= (mode_q != MODE_RUN) && (mode_d == MODE_RUN);
            resume_isr_q <= ((mode_q == MODE_IDLE) || (mode_q == MODE_SLEEP))
                            && irq_hit_i && !mclr_i;
        end
    end

    assign mode_q_o     = mode_q;
    assign mode_d_o     = mode_d;
    assign wdt_clr_o    = wdt_clr_q;
    assign resume_o     = resume_q;
    assign resume_isr_o = resume_isr_q;
endmodule

// File: rtl/lpm_seq.sv
// Low-power mode entry sequencer top: wires the interrupt screen, arm
// guard, wake log and mode machine, and decodes the clock gates.
// Assumes: all inputs are synchronous to clk; rst_n is the power-on reset.
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int N_IRQ   = 8,
    parameter int GAP_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwrsav_i,
    input  logic             pwrsav_op_i,
    input  logic             arm_set_i,
    input  logic             rel_clr_i,
    input  logic             mclr_i,
    input  logic             wdt_to_i,
    input  logic [N_IRQ-1:0] irq_pend_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    input  logic             rtc_alarm_i,
    input  logic             ext_int0_i,
    input  logic             dswdt_to_i,
    output logic [1:0]       mode_o,
    output logic             arm_o,
    output logic [4:0]       wake_cause_o,
    output logic             cpu_clk_en_o,
    output logic             sys_clk_en_o,
    output logic             wdt_clr_o,
    output logic             ds_en_o,
    output logic             resume_o,
    output logic             resume_isr_o
);
    pmode_e            mode_q, mode_d;
    logic              irq_hit, arm, arm_load, gap_ok;
    logic              deep_exit, ds_wake;
    logic [WSRC_N-1:0] src_vec;

    // deep-sleep wake sources in cause-bit order
    always_comb begin
        src_vec            = '0;
        src_vec[WB_MCLR]   = mclr_i;
        src_vec[WB_RTC]    = rtc_alarm_i;
        src_vec[WB_INT0]   = ext_int0_i;
        src_vec[WB_DSWDT]  = dswdt_to_i;
    end

    assign ds_wake   = rtc_alarm_i || ext_int0_i || dswdt_to_i;
    assign deep_exit = (mode_q == MODE_DEEP) && (mode_d == MODE_RUN);

    lpm_irq_screen #(.N_IRQ(N_IRQ)) irq_i (
        .pend_i (irq_pend_i),
        .en_i   (irq_en_i),
        .hit_o  (irq_hit)
    );

    lpm_arm_guard #(.GAP_CYC(GAP_CYC)) guard_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_set_i   (arm_set_i),
        .rel_clr_i   (rel_clr_i),
        .mclr_i      (mclr_i),
        .run_i       (mode_q == MODE_RUN),
        .cmd_i       (pwrsav_i),
        .stay_deep_i (mode_d == MODE_DEEP),
        .deep_exit_i (deep_exit),
        .arm_o       (arm),
        .arm_load_o  (arm_load),
        .gap_ok_o    (gap_ok)
    );

    lpm_wake_log wlog_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (arm_load),
        .capture_i (mode_q == MODE_DEEP),
        .src_i     (src_vec),
        .cause_o   (wake_cause_o)
    );

    lpm_mode_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwrsav_i     (pwrsav_i),
        .pwrsav_op_i  (pwrsav_op_i),
        .arm_i        (arm),
        .gap_ok_i     (gap_ok),
        .mclr_i       (mclr_i),
        .wdt_to_i     (wdt_to_i),
        .irq_hit_i    (irq_hit),
        .ds_wake_i    (ds_wake),
        .mode_q_o     (mode_q),
        .mode_d_o     (mode_d),
        .wdt_clr_o    (wdt_clr_o),
        .resume_o     (resume_o),
        .resume_isr_o (resume_isr_o)
    );

    // clock gates and domain enable follow the current mode
    assign mode_o       = mode_q;
    assign arm_o        = arm;
    assign cpu_clk_en_o = (mode_q == MODE_RUN);
    assign sys_clk_en_o = (mode_q == MODE_RUN) || (mode_q == MODE_IDLE);
    assign ds_en_o      = (mode_q == MODE_DEEP);
endmodule

// File: rtl/lpm_seq_chk.sv
// Property checker for the sequencer, bound to the top by port names.
module lpm_seq_chk #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwrsav_i,
    input logic             pwrsav_op_i,
    input logic             arm_set_i,
    input logic             mclr_i,
    input logic [N_IRQ-1:0] irq_pend_i,
    input logic [N_IRQ-1:0] irq_en_i,
    input logic             rtc_alarm_i,
    input logic             ext_int0_i,
    input logic             dswdt_to_i,
    input logic [1:0]       mode_o,
    input logic             arm_o,
    input logic [4:0]       wake_cause_o,
    input logic             cpu_clk_en_o,
    input logic             sys_clk_en_o,
    input logic             wdt_clr_o,
    input logic             ds_en_o,
    input logic             resume_o
);
    logic irq_any;
    assign irq_any = |(irq_pend_i & irq_en_i);

    AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd1 |-> !cpu_clk_en_o && sys_clk_en_o); // R1
    AST_WDT_CLR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |-> mode_o == 2'd1 && $past(mode_o) == 2'd0); // R1
    AST_IDLE_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && irq_any) |=> mode_o == 2'd0 && resume_o); // R2
    AST_COINCIDENT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && pwrsav_i && pwrsav_op_i && !mclr_i) |=> mode_o == 2'd1); // R3
    AST_ARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_o && mode_o == 2'd0 && !arm_set_i) |=> (!arm_o || mode_o == 2'd3)); // R4
    AST_UNARMED_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && pwrsav_i && !pwrsav_op_i && !arm_o && !mclr_i) |=> mode_o == 2'd2); // R4
    AST_DEEP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd3 |-> arm_o && ds_en_o); // R5
    AST_DEEP_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd3 |=> (mode_o == 2'd3 || !arm_o)); // R5
    AST_DEEP_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3 && !mclr_i && !rtc_alarm_i && !ext_int0_i && !dswdt_to_i) |=> mode_o == 2'd3); // R6
    AST_ARM_CLEARS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(arm_o) && mode_o == 2'd0) |-> wake_cause_o == 5'd0); // R7
    AST_SLEEP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd2 |-> !cpu_clk_en_o && !sys_clk_en_o); // R10
endmodule

bind lpm_seq lpm_seq_chk #(.N_IRQ(N_IRQ)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwrsav_i     (pwrsav_i),
    .pwrsav_op_i  (pwrsav_op_i),
    .arm_set_i    (arm_set_i),
    .mclr_i       (mclr_i),
    .irq_pend_i   (irq_pend_i),
    .irq_en_i     (irq_en_i),
    .rtc_alarm_i  (rtc_alarm_i),
    .ext_int0_i   (ext_int0_i),
    .dswdt_to_i   (dswdt_to_i),
    .mode_o       (mode_o),
    .arm_o        (arm_o),
    .wake_cause_o (wake_cause_o),
    .cpu_clk_en_o (cpu_clk_en_o),
    .sys_clk_en_o (sys_clk_en_o),
    .wdt_clr_o    (wdt_clr_o),
    .ds_en_o      (ds_en_o),
    .resume_o     (resume_o)
);

// File: tb/lpm_seq_tb_top.sv
module lpm_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_IRQ      = 8;

    logic clk = 1'b0;
    logic rst_n, pwrsav, pwrsav_op, arm_set, rel_clr, mclr, wdt_to;
    logic rtc, int0, dswdt;
    logic [N_IRQ-1:0] pend, en;
    logic [1:0] mode;
    logic arm, cpu_en, sys_en, wdt_clr, ds_en, resume, resume_isr;
    logic [4:0] cause;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_seq #(.N_IRQ(N_IRQ), .GAP_CYC(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwrsav_i(pwrsav), .pwrsav_op_i(pwrsav_op),
        .arm_set_i(arm_set), .rel_clr_i(rel_clr), .mclr_i(mclr), .wdt_to_i(wdt_to),
        .irq_pend_i(pend), .irq_en_i(en), .rtc_alarm_i(rtc), .ext_int0_i(int0),
        .dswdt_to_i(dswdt), .mode_o(mode), .arm_o(arm), .wake_cause_o(cause),
        .cpu_clk_en_o(cpu_en), .sys_clk_en_o(sys_en), .wdt_clr_o(wdt_clr),
        .ds_en_o(ds_en), .resume_o(resume), .resume_isr_o(resume_isr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // advance to the next falling edge (one rising edge in between)
    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet();
        pwrsav = 0; pwrsav_op = 0; arm_set = 0; rel_clr = 0; mclr = 0;
        wdt_to = 0; rtc = 0; int0 = 0; dswdt = 0; pend = '0; en = '0;
    endtask

    // arm, then sleep command on the next edge
    task automatic enter_deep();
        arm_set = 1; step(); arm_set = 0;
        pwrsav = 1; pwrsav_op = 0; step(); pwrsav = 0;
    endtask

    initial begin
        quiet();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
        // R9 reset state
        chk("R9 mode", mode, 0);
        chk("R9 arm", arm, 0);
        chk("R9 cause", cause, 5'b00001);
        chk("R9 cpu_en", cpu_en, 1);
        chk("R9 ds_en", ds_en, 0);

        // R1/R2 idle sweep over every line with enable on and off
        for (int i = 0; i < N_IRQ; i++) begin
            for (int e = 0; e < 2; e++) begin
                pwrsav = 1; pwrsav_op = 1; step(); pwrsav = 0;
                chk("R1 idle mode", mode, 1);
                chk("R1 idle cpu gate", cpu_en, 0);
                chk("R1 idle sys clk", sys_en, 1);
                chk("R1 wdt clear", wdt_clr, 1);
                pend = N_IRQ'(1) << i;
                en   = (e == 1) ? pend : ~pend;
                step();
                if (e == 1) begin
                    chk("R2 irq wake", mode, 0);
                    chk("R2 resume", resume, 1);
                    chk("R2 isr", resume_isr, 1);
                end else begin
                    chk("R2 masked stays idle", mode, 1);
                    chk("R1 wdt pulse single", wdt_clr, 0);
                    pend = '0; wdt_to = 1; step(); wdt_to = 0;
                    chk("R2 wdt wake", mode, 0);
                    chk("R2 wdt resume", resume, 1);
                    chk("R2 wdt not isr", resume_isr, 0);
                end
                pend = '0; en = '0;
                step();
            end
        end

        // R3 coincident interrupt
        pend = 8'h10; en = 8'h10; pwrsav = 1; pwrsav_op = 1; step(); pwrsav = 0;
        chk("R3 entry completes", mode, 1);
        step();
        chk("R3 wakes next", mode, 0);
        chk("R3 isr", resume_isr, 1);
        pend = '0; en = '0; step();

        // R10/R2 plain sleep, mclr wake
        pwrsav = 1; pwrsav_op = 0; step(); pwrsav = 0;
        chk("R4 unarmed sleep", mode, 2);
        chk("R10 cpu off", cpu_en, 0);
        chk("R10 sys off", sys_en, 0);
        mclr = 1; step(); mclr = 0;
        chk("R2 mclr wake", mode, 0);
        chk("R2 mclr resume", resume, 1);
        chk("R2 mclr not isr", resume_isr, 0);
        step();

        // R4/R7 late command after arming
        arm_set = 1; step(); arm_set = 0;
        chk("R4 arm set", arm, 1);
        chk("R7 cause wiped", cause, 0);
        step();
        chk("R4 arm self clears", arm, 0);
        chk("R4 still run", mode, 0);
        pwrsav = 1; pwrsav_op = 0; step(); pwrsav = 0;
        chk("R4 late cmd is sleep", mode, 2);
        wdt_to = 1; step(); wdt_to = 0; step();

        // R5/R6 each deep source alone
        for (int s = 1; s < 5; s++) begin
            enter_deep();
            chk("R4 deep entered", mode, 3);
            chk("R5 ds_en", ds_en, 1);
            chk("R5 armed in deep", arm, 1);
            pend = '1; en = '1; wdt_to = 1; step();
            chk("R6 ignores irq/wdt", mode, 3);
            pend = '0; en = '0; wdt_to = 0;
            mclr = (s == 1); rtc = (s == 2); int0 = (s == 3); dswdt = (s == 4);
            step(); quiet();
            chk("R6 deep exit", mode, 0);
            chk("R5 disarm on exit", arm, 0);
            chk("R5 ds_en off", ds_en, 0);
            chk("R6 cause bit", cause, 32'(1) << s);
            step();
        end
        // R6 all sources accumulate
        enter_deep();
        mclr = 1; rtc = 1; int0 = 1; dswdt = 1; step(); quiet();
        chk("R6 all causes", cause, 5'b11110);
        step();

        // R8 gap sweep
        for (int a = 1; a <= 5; a++) begin
            rel_clr = 1; step(); rel_clr = 0;
            repeat (a - 1) step();
            arm_set = 1; step(); arm_set = 0;
            pwrsav = 1; pwrsav_op = 0; step(); pwrsav = 0;
            chk("R8 gap decision", mode, (a >= 3) ? 3 : 0);
            if (a >= 3) begin
                int0 = 1; step(); int0 = 0;
            end else begin
                chk("R8 dropped disarms", arm, 0);
            end
            step();
        end

        // R9 reset during deep sleep
        enter_deep();
        chk("R9 pre deep", mode, 3);
        rst_n = 0; step(); rst_n = 1; step();
        chk("R9 reset to run", mode, 0);
        chk("R9 reset disarm", arm, 0);
        chk("R9 reset cause", cause, 5'b00001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule